// File: doc/BRIEF.md
# Exception Priority Level and Nesting Tracker

This block keeps the processor's current 4-bit execution priority level. It also handles nested entry into and return from exception handlers. An arbiter in front of it offers at most one exception at a time, as a valid flag, a level and a vector number. The block compares the offered level with the current level. When it takes the offer, it saves the core's status bits, the current level and the return address in an internal last-in-first-out store. It then raises the current level to the offered one and emits a one-cycle take pulse that carries the vector and the saved address.

A return pulse from the core unwinds one saved frame. The block restores the level exactly and reports the saved address and status on a one-cycle return pulse. Because the restore is exact, a lower request that was held back is taken only after the higher handler has left.

Levels 8 to 15 belong to traps, and their top bit can only be set by taking an offer. Software may rewrite the three low level bits to mask interrupts temporarily, but not while a trap is being handled. Overflow and underflow of the frame store do not damage state. Each raises a sticky error flag that only reset clears.

Top module: `prio_nest_tracker`

## Requirements
- R1: After reset, `cur_lvl` is 0, `take_o`, `ret_o` and `stk_err` are 0.
- R2: An offer is taken only when `offer_lvl` is strictly greater than `cur_lvl`. An equal or lower offer leaves the level unchanged and gives no take pulse.
- R3: One cycle after the clock edge that takes an offer, `take_o` is 1 for one cycle, `take_vec` equals the offered vector, `take_pc` equals `pc_i` of that cycle, and `cur_lvl` equals the offered level.
- R4: A `reti` pulse with at least one saved frame gives `ret_o` for one cycle, with `ret_pc`/`ret_stat` equal to the `pc_i`/`stat_i` saved by the matching take. `cur_lvl` returns to the level held before that take.
- R5: Frames unwind in reverse order of taking, so nested handlers return through every intermediate level.
- R6: With `cur_lvl` bit 3 clear, `sw_wr` sets `cur_lvl` to {0, `sw_lvl`}, lowering or raising the mask.
- R7: With `cur_lvl` bit 3 set (trap context), `sw_wr` has no effect on `cur_lvl`. Bit 3 becomes set only by taking an offer of level 8 or more.
- R8: When `reti` and a takeable offer occur in the same cycle, only the return is performed. The still-present offer is compared with the restored level in the next cycle.
- R9: An offer that would be taken while DEPTH frames are saved is refused: no take pulse, level unchanged. `stk_err` becomes 1 and stays 1 until reset.
- R10: A `reti` with no saved frame gives no return pulse and leaves the level unchanged. It sets the sticky `stk_err`.
- R11: A take in the same cycle as `sw_wr` wins over the write. A `reti` in the same cycle as `sw_wr` also wins over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| offer_vld | input | 1 | Arbiter presents an exception |
| offer_lvl | input | 4 | Level of the offered exception |
| offer_vec | input | VEC_W | Vector number of the offered exception |
| pc_i | input | PC_W | Return address to save on a take |
| stat_i | input | STAT_W | Other core status bits to save on a take |
| reti | input | 1 | Return-from-exception pulse |
| sw_wr | input | 1 | Software write of the low level bits |
| sw_lvl | input | 3 | Value for the low level bits |
| cur_lvl | output | 4 | Current priority level |
| take_o | output | 1 | One-cycle pulse: offer taken |
| take_vec | output | VEC_W | Vector of the taken offer |
| take_pc | output | PC_W | Address saved by the take |
| ret_o | output | 1 | One-cycle pulse: frame restored |
| ret_pc | output | PC_W | Restored resume address |
| ret_stat | output | STAT_W | Restored status bits |
| stk_err | output | 1 | Sticky overflow/underflow flag |

## Verification
The hardest state to reach from the ports is a full frame store. Levels must rise strictly on each take, so a chain of takes alone ends at level 15 before sixteen frames exist. The bench builds a reduced-depth instance and alternates a level-1 take with a software write back to level 0, stacking one frame per pair until the store is full. It then offers again to provoke the overflow. It unwinds the frames afterwards to confirm that the overflow altered none of them. Underflow is reached from a fresh reset with a single return pulse.

// File: rtl/pnt_pkg.sv
package pnt_pkg;
  localparam int LVL_W    = 4;
  localparam int TRAP_BIT = LVL_W - 1;
  localparam int USR_W    = LVL_W - 1;
  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [USR_W-1:0] usr_lvl_t;
endpackage

// File: rtl/pnt_stack.sv
module pnt_stack #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] top_idx;
  logic [W-1:0]  rd_arr [DEPTH];

  // one storage slot per entry, written only when it is the next free one
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] slot_q;
    logic         slot_en;
    assign slot_en = push && (cnt_q == CW'(i));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q <= din;
    end
    assign rd_arr[i] = slot_q;
  end

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign top_idx = IW'(cnt_q - 1'b1);
  assign dout    = empty ? '0 : rd_arr[top_idx];

  always_comb begin
    cnt_d = cnt_q;
    if (push)     cnt_d = cnt_q + 1'b1;
    else if (pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_no_push_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_push_pop_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/pnt_gate.sv
module pnt_gate
  import pnt_pkg::*;
(
  input  logic offer_vld,
  input  lvl_t offer_lvl,
  input  lvl_t lvl_q,
  input  logic reti,
  input  logic sw_wr,
  input  logic full,
  input  logic empty,
  output logic do_take,
  output logic do_ret,
  output logic do_sw,
  output logic err_set
);
  logic want, push_err, pop_err;

  always_comb begin
    // a return pulse blocks every other action in its cycle
    want     = offer_vld && !reti && (offer_lvl > lvl_q);
    do_take  = want && !full;
    push_err = want && full;
    do_ret   = reti && !empty;
    pop_err  = reti && empty;
    do_sw    = sw_wr && !reti && !want && !lvl_q[TRAP_BIT];
    err_set  = push_err || pop_err;
  end
endmodule

// File: rtl/pnt_level.sv
module pnt_level
  import pnt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     take_evt,
  input  logic     ret_evt,
  input  logic     sw_evt,
  input  lvl_t     offer_lvl,
  input  lvl_t     pop_lvl,
  input  usr_lvl_t sw_lvl,
  output lvl_t     lvl_q
);
  lvl_t lvl_d;

  always_comb begin
    lvl_d = lvl_q;
    if (ret_evt)       lvl_d = pop_lvl;
    else if (take_evt) lvl_d = offer_lvl;
    else if (sw_evt)   lvl_d = {1'b0, sw_lvl};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  p_trap_bit_core_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl_q[TRAP_BIT]) |-> $past(take_evt));
  p_sw_no_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_evt |-> !lvl_q[TRAP_BIT]);
endmodule

// File: rtl/prio_nest_tracker.sv
module prio_nest_tracker
  import pnt_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int PC_W   = 24,
  parameter int VEC_W  = 9,
  parameter int STAT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              offer_vld,
  input  logic [3:0]        offer_lvl,
  input  logic [VEC_W-1:0]  offer_vec,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic              reti,
  input  logic              sw_wr,
  input  logic [2:0]        sw_lvl,
  output logic [3:0]        cur_lvl,
  output logic              take_o,
  output logic [VEC_W-1:0]  take_vec,
  output logic [PC_W-1:0]   take_pc,
  output logic              ret_o,
  output logic [PC_W-1:0]   ret_pc,
  output logic [STAT_W-1:0] ret_stat,
  output logic              stk_err
);
  localparam int FR_W = STAT_W + LVL_W + PC_W;

  // reset: asserted at once, released through two flops
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  lvl_t            lvl_q, pop_lvl;
  logic            do_take, do_ret, do_sw, err_set, full, empty;
  logic [FR_W-1:0] push_fr, pop_fr;

  assign push_fr = {stat_i, lvl_q, pc_i};
  assign pop_lvl = pop_fr[PC_W +: LVL_W];

  pnt_gate u_gate (
    .offer_vld (offer_vld),
    .offer_lvl (offer_lvl),
    .lvl_q     (lvl_q),
    .reti      (reti),
    .sw_wr     (sw_wr),
    .full      (full),
    .empty     (empty),
    .do_take   (do_take),
    .do_ret    (do_ret),
    .do_sw     (do_sw),
    .err_set   (err_set)
  );

  pnt_stack #(.DEPTH(DEPTH), .W(FR_W)) u_stack (
    .clk   (clk),
    .rst_n (rst_i_n),
    .push  (do_take),
    .pop   (do_ret),
    .din   (push_fr),
    .dout  (pop_fr),
    .full  (full),
    .empty (empty)
  );

  pnt_level u_level (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .take_evt  (do_take),
    .ret_evt   (do_ret),
    .sw_evt    (do_sw),
    .offer_lvl (offer_lvl),
    .pop_lvl   (pop_lvl),
    .sw_lvl    (sw_lvl),
    .lvl_q     (lvl_q)
  );

  // output event registers
  logic              take_q, take_d, ret_q, ret_d, err_q, err_d;
  logic [VEC_W-1:0]  tvec_q, tvec_d;
  logic [PC_W-1:0]   tpc_q, tpc_d, rpc_q, rpc_d;
  logic [STAT_W-1:0] rst_q, rst_d;

  always_comb begin
    take_d = do_take;
    ret_d  = do_ret;
    err_d  = err_q || err_set;
    tvec_d = tvec_q;
    tpc_d  = tpc_q;
    rpc_d  = rpc_q;
    rst_d  = rst_q;
    if (do_take) begin
      tvec_d = offer_vec;
      tpc_d  = pc_i;
    end
    if (do_ret) begin
      rpc_d = pop_fr[PC_W-1:0];
      rst_d = pop_fr[FR_W-1 -: STAT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      take_q <= 1'b0;
      ret_q  <= 1'b0;
      err_q  <= 1'b0;
      tvec_q <= '0;
      tpc_q  <= '0;
      rpc_q  <= '0;
      rst_q  <= '0;
    end else begin
      take_q <= take_d;
      ret_q  <= ret_d;
      err_q  <= err_d;
      tvec_q <= tvec_d;
      tpc_q  <= tpc_d;
      rpc_q  <= rpc_d;
      rst_q  <= rst_d;
    end
  end

  assign cur_lvl  = lvl_q;
  assign take_o   = take_q;
  assign take_vec = tvec_q;
  assign take_pc  = tpc_q;
  assign ret_o    = ret_q;
  assign ret_pc   = rpc_q;
  assign ret_stat = rst_q;
  assign stk_err  = err_q;

  p_take_raises_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    take_o |-> (cur_lvl > $past(cur_lvl)));
  p_take_lvl_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    $past(do_take) |-> (cur_lvl == $past(offer_lvl)));
  p_ret_blocks_take_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    $past(reti) |-> !take_o);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    stk_err |=> stk_err);
  p_sw_trap_ignored_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    $past(sw_wr && cur_lvl[3] && !reti && !offer_vld) |-> $stable(cur_lvl));
  p_ret_excl_take_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(take_o && ret_o));
endmodule

// File: tb/sim_prio_nest_tracker.sv
module sim_prio_nest_tracker;
  localparam int DEPTH  = 4;
  localparam int PC_W   = 24;
  localparam int VEC_W  = 9;
  localparam int STAT_W = 12;

  typedef struct packed {
    logic              ov;
    logic [3:0]        ol;
    logic [VEC_W-1:0]  vec;
    logic [PC_W-1:0]   pc;
    logic [STAT_W-1:0] st;
    logic              rt;
    logic              sw;
    logic [2:0]        swl;
    logic              etk;
    logic [VEC_W-1:0]  etv;
    logic [PC_W-1:0]   etp;
    logic [3:0]        elv;
    logic              erv;
    logic [PC_W-1:0]   erp;
    logic [STAT_W-1:0] ers;
  } row_t;

  function automatic row_t mk(int ov, int ol, int vec, int pc, int st, int rt,
                              int sw, int swl, int etk, int etv, int etp,
                              int elv, int erv, int erp, int ers);
    row_t r;
    r.ov = ov[0];            r.ol = ol[3:0];
    r.vec = vec[VEC_W-1:0];  r.pc = pc[PC_W-1:0];
    r.st = st[STAT_W-1:0];   r.rt = rt[0];
    r.sw = sw[0];            r.swl = swl[2:0];
    r.etk = etk[0];          r.etv = etv[VEC_W-1:0];
    r.etp = etp[PC_W-1:0];   r.elv = elv[3:0];
    r.erv = erv[0];          r.erp = erp[PC_W-1:0];
    r.ers = ers[STAT_W-1:0];
    return r;
  endfunction

  localparam int NROW = 18;
  localparam row_t TBL [NROW] = '{
    mk(0, 0, 0, 0,     0,     0, 0, 0, 0, 0, 0,     0,  0, 0,     0),
    mk(1, 0, 1, 0,     0,     0, 0, 0, 0, 0, 0,     0,  0, 0,     0),
    mk(1, 1, 5, 'h100, 'hA1,  0, 0, 0, 1, 5, 'h100, 1,  0, 0,     0),
    mk(1, 1, 5, 'h100, 'hA1,  0, 0, 0, 0, 0, 0,     1,  0, 0,     0),
    mk(1, 3, 9, 'h200, 'hB2,  0, 0, 0, 1, 9, 'h200, 3,  0, 0,     0),
    mk(1, 2, 7, 'h300, 'hC3,  0, 0, 0, 0, 0, 0,     3,  0, 0,     0),
    mk(1, 2, 7, 'h300, 'hC3,  1, 0, 0, 0, 0, 0,     1,  1, 'h200, 'hB2),
    mk(1, 2, 7, 'h300, 'hC3,  0, 0, 0, 1, 7, 'h300, 2,  0, 0,     0),
    mk(0, 0, 0, 0,     0,     1, 0, 0, 0, 0, 0,     1,  1, 'h300, 'hC3),
    mk(0, 0, 0, 0,     0,     1, 0, 0, 0, 0, 0,     0,  1, 'h100, 'hA1),
    mk(0, 0, 0, 0,     0,     0, 1, 5, 0, 0, 0,     5,  0, 0,     0),
    mk(1, 4, 4, 'h350, 0,     0, 0, 0, 0, 0, 0,     5,  0, 0,     0),
    mk(1, 9, 2, 'h400, 'hD4,  0, 1, 1, 1, 2, 'h400, 9,  0, 0,     0),
    mk(0, 0, 0, 0,     0,     0, 1, 2, 0, 0, 0,     9,  0, 0,     0),
    mk(1, 12, 3, 'h500, 'hE5, 0, 0, 0, 1, 3, 'h500, 12, 0, 0,     0),
    mk(0, 0, 0, 0,     0,     1, 1, 0, 0, 0, 0,     9,  1, 'h500, 'hE5),
    mk(0, 0, 0, 0,     0,     1, 0, 0, 0, 0, 0,     5,  1, 'h400, 'hD4),
    mk(0, 0, 0, 0,     0,     0, 1, 0, 0, 0, 0,     0,  0, 0,     0)
  };

  function automatic string tag_of(int i);
    case (i)
      1, 3, 5, 11: return "R2";
      2, 4:        return "R3/R5";
      6:           return "R8/R4";
      7:           return "R8";
      8:           return "R4";
      9, 16:       return "R5";
      10, 17:      return "R6";
      12, 15:      return "R11";
      13:          return "R7";
      14:          return "R7/R3";
      default:     return "R1";
    endcase
  endfunction

  logic              clk, rst_n;
  logic              offer_vld, reti, sw_wr;
  logic [3:0]        offer_lvl;
  logic [VEC_W-1:0]  offer_vec;
  logic [PC_W-1:0]   pc_i;
  logic [STAT_W-1:0] stat_i;
  logic [2:0]        sw_lvl;
  logic [3:0]        cur_lvl;
  logic              take_o, ret_o, stk_err;
  logic [VEC_W-1:0]  take_vec;
  logic [PC_W-1:0]   take_pc, ret_pc;
  logic [STAT_W-1:0] ret_stat;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  prio_nest_tracker #(.DEPTH(DEPTH), .PC_W(PC_W), .VEC_W(VEC_W), .STAT_W(STAT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .offer_vld(offer_vld), .offer_lvl(offer_lvl),
    .offer_vec(offer_vec), .pc_i(pc_i), .stat_i(stat_i), .reti(reti),
    .sw_wr(sw_wr), .sw_lvl(sw_lvl), .cur_lvl(cur_lvl), .take_o(take_o),
    .take_vec(take_vec), .take_pc(take_pc), .ret_o(ret_o), .ret_pc(ret_pc),
    .ret_stat(ret_stat), .stk_err(stk_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    offer_vld = 1'b0; offer_lvl = '0; offer_vec = '0; pc_i = '0;
    stat_i = '0; reti = 1'b0; sw_wr = 1'b0; sw_lvl = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic cyc(logic ov, logic [3:0] ol, logic [PC_W-1:0] pc, logic rt,
                     logic sw, logic [2:0] swl);
    offer_vld = ov; offer_lvl = ol; offer_vec = 9'd1; pc_i = pc;
    stat_i = 12'h5A; reti = rt; sw_wr = sw; sw_lvl = swl;
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1", "reset cur_lvl", cur_lvl, 0);
    chk("R1", "reset take_o", take_o, 0);
    chk("R1", "reset ret_o", ret_o, 0);
    chk("R1", "reset stk_err", stk_err, 0);

    for (int i = 0; i < NROW; i++) begin
      row_t r;
      r = TBL[i];
      offer_vld = r.ov; offer_lvl = r.ol; offer_vec = r.vec; pc_i = r.pc;
      stat_i = r.st; reti = r.rt; sw_wr = r.sw; sw_lvl = r.swl;
      @(posedge clk);
      @(negedge clk);
      chk(tag_of(i), $sformatf("row %0d cur_lvl", i), cur_lvl, r.elv);
      chk(tag_of(i), $sformatf("row %0d take_o", i), take_o, r.etk);
      if (r.etk) begin
        chk(tag_of(i), $sformatf("row %0d take_vec", i), take_vec, r.etv);
        chk(tag_of(i), $sformatf("row %0d take_pc", i), take_pc, r.etp);
      end
      chk(tag_of(i), $sformatf("row %0d ret_o", i), ret_o, r.erv);
      if (r.erv) begin
        chk(tag_of(i), $sformatf("row %0d ret_pc", i), ret_pc, r.erp);
        chk(tag_of(i), $sformatf("row %0d ret_stat", i), ret_stat, r.ers);
      end
      chk(tag_of(i), $sformatf("row %0d stk_err", i), stk_err, 0);
    end
    idle_inputs();

    // R10: return with nothing saved
    do_reset();
    cyc(1'b0, 4'd0, '0, 1'b1, 1'b0, 3'd0);
    chk("R10", "empty pop ret_o", ret_o, 0);
    chk("R10", "empty pop cur_lvl", cur_lvl, 0);
    chk("R10", "empty pop stk_err", stk_err, 1);
    cyc(1'b0, 4'd0, '0, 1'b0, 1'b0, 3'd0);
    chk("R10", "stk_err sticky", stk_err, 1);

    // R9: fill the store by take / software lower pairs, then overflow
    do_reset();
    chk("R1", "reset clears stk_err", stk_err, 0);
    for (int k = 1; k <= DEPTH; k++) begin
      cyc(1'b1, 4'd1, PC_W'(k), 1'b0, 1'b0, 3'd0);
      chk("R9", $sformatf("fill take %0d", k), take_o, 1);
      cyc(1'b0, 4'd0, '0, 1'b0, 1'b1, 3'd0);
      chk("R6", $sformatf("fill lower %0d", k), cur_lvl, 0);
    end
    cyc(1'b1, 4'd1, 24'h99, 1'b0, 1'b0, 3'd0);
    chk("R9", "overflow take_o", take_o, 0);
    chk("R9", "overflow cur_lvl", cur_lvl, 0);
    chk("R9", "overflow stk_err", stk_err, 1);
    for (int k = DEPTH; k >= 1; k--) begin
      cyc(1'b0, 4'd0, '0, 1'b1, 1'b0, 3'd0);
      chk("R5", $sformatf("unwind %0d ret_o", k), ret_o, 1);
      chk("R5", $sformatf("unwind %0d ret_pc", k), ret_pc, k);
      chk("R9", $sformatf("unwind %0d stk_err", k), stk_err, 1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule